// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Core

This block is a synthesizable model of an asynchronous static memory, 16 bits wide, with a 17-bit word address at full size. It has active-low pins for chip select, write strobe, output gate and one enable per byte lane. The shared bidirectional data bus is split into three parts: a data-in bus, a data-out bus and one drive-enable per byte lane. A pad ring or a bench joins them into a tri-state bus.

A clock that runs much faster than the control edges samples the control pins. A small state machine follows the decoded bus mode. It has four states: `ST_STANDBY`, `ST_READ`, `ST_OUTOFF` and `ST_WRITE`. A new decode moves it into another state on every clock. When it leaves `ST_WRITE`, it commits the data that was latched at the last edge inside the write window. The lane drivers and the standby flag follow the current pins combinationally.

The default depth is 1024 words (`ADDR_W = 10`) so that the model stays small. Setting `ADDR_W = 17` gives the full 131,072-word array.

Top module: `sram_bytelane_core`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, with lanes of 8 bits. A word read back returns the bytes last written to it.
- R2: A write window is open while `ce_n`=0, `we_n`=0 and at least one `be_n` bit is 0. The write commits on the clock edge after the window closes. It stores the `addr`, `din` and lane mask that were sampled at the last clock edge inside the window.
- R3: Bit `be_n[0]` gates lane 0 (bits 7:0) and bit `be_n[1]` gates lane 1 (bits 15:8). A write leaves every lane whose enable is 1 unchanged.
- R4: With `ce_n`=0, `we_n`=1 and `oe_n`=0, `dout_en[i]` is 1 exactly when `be_n[i]` is 0. Each driven lane shows the stored byte at `addr`.
- R5: While `ce_n`=1, `standby` is 1 and every `dout_en` bit is 0, whatever the other pins are doing.
- R6: When `ce_n`=0 and all `be_n` bits are 1, `standby` is 1, no lane is driven and nothing is written.
- R7: When `ce_n`=0, `we_n`=1, `oe_n`=1 and some lane is enabled, the block is in output-off mode: `standby` is 0 and no lane is driven.
- R8: While `ce_n`=0 and `we_n`=0, no lane is driven, even when `oe_n`=0.
- R9: A rise of `ce_n` ends a write in the same way as a rise of `we_n`.
- R10: After reset with all control pins high, `standby` is 1 and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the control edges |
| rst_n | input | 1 | Active-low reset of the mode state and write latch |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| be_n | input | LANES | Per-lane byte enables, active low (bit 0 = bits 7:0) |
| din | input | DATA_W | Data from the bus |
| dout | output | DATA_W | Data to the bus |
| dout_en | output | LANES | Per-lane drive enable |
| standby | output | 1 | High in both standby conditions |

## Verification
The assertions check the pin-level decode on every cycle. They cover the blanked lanes during chip deselect, during a write window and in output-off mode, the standby flag in both standby cases, and the rule that a commit only follows a closed write window. The bench scenarios are the only source of evidence for stored contents. They cover the last-edge data capture, the two ways of ending a write, and partial-lane merging, each checked against a shadow array over all 32 pin combinations and a 64-word sweep.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_READ    = 2'd1,
        ST_OUTOFF  = 2'd2,
        ST_WRITE   = 2'd3
    } bus_mode_e;

    localparam int LANE_W = 8;
endpackage

// File: rtl/sram_mode_fsm.sv
module sram_mode_fsm
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [DATA_W-1:0] din,
    output logic [LANES-1:0]  lane_drive,
    output logic              standby,
    output logic [LANES-1:0]  commit_lanes,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    bus_mode_e state_q, mode_d;
    logic [LANES-1:0]  lat_lanes_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_data_q;

    // Mode decode, priority: deselect, no lane, write, output gate.
    always_comb begin
        if (ce_n)
            mode_d = ST_STANDBY;
        else if (&be_n)
            mode_d = ST_STANDBY;
        else if (!we_n)
            mode_d = ST_WRITE;
        else if (oe_n)
            mode_d = ST_OUTOFF;
        else
            mode_d = ST_READ;
    end

    // State register and write latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_STANDBY;
            lat_lanes_q <= '0;
            lat_addr_q  <= '0;
            lat_data_q  <= '0;
        end else begin
            state_q <= mode_d;
            if (mode_d == ST_WRITE) begin
                lat_lanes_q <= ~be_n;
                lat_addr_q  <= addr;
                lat_data_q  <= din;
            end
        end
    end

    // Output process.
    always_comb begin
        lane_drive   = '0;
        standby      = 1'b0;
        commit_lanes = '0;
        unique case (mode_d)
            ST_STANDBY: standby    = 1'b1;
            ST_READ:    lane_drive = ~be_n;
            ST_OUTOFF:  lane_drive = '0;
            ST_WRITE:   lane_drive = '0;
            default:    lane_drive = '0;
        endcase
        if (state_q == ST_WRITE && mode_d != ST_WRITE)
            commit_lanes = lat_lanes_q;
    end
    assign commit_addr = lat_addr_q;
    assign commit_data = lat_data_q;

    AST_WR_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> (lane_drive == '0)); // R8
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (standby && lane_drive == '0)); // R5
    AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && &be_n) |-> (standby && lane_drive == '0 && commit_lanes == '0)); // R6
    AST_OUTOFF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n && !(&be_n)) |-> (!standby && lane_drive == '0)); // R7
    AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_lanes != '0) |-> ($past(!ce_n && !we_n && !(&be_n)) && (ce_n || we_n || &be_n))); // R2
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sram_bytelane_core.sv
module sram_bytelane_core
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dout_en,
    output logic              standby
);
    logic [LANES-1:0]  commit_lanes;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;

    sram_mode_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .ce_n         (ce_n),
        .we_n         (we_n),
        .oe_n         (oe_n),
        .be_n         (be_n),
        .din          (din),
        .lane_drive   (dout_en),
        .standby      (standby),
        .commit_lanes (commit_lanes),
        .commit_addr  (commit_addr),
        .commit_data  (commit_data)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk      (clk),
        .wr_lanes (commit_lanes),
        .wr_addr  (commit_addr),
        .wr_data  (commit_data),
        .rd_addr  (addr),
        .rd_data  (dout)
    );

    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |-> (dout_en == ~be_n)); // R4
endmodule

// File: tb/sram_bytelane_core_bench.sv
module sram_bytelane_core_bench;
    localparam int AW = 10;
    localparam int LN = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [LN-1:0] be_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic [LN-1:0] dout_en;
    logic          standby;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] shadow [1 << AW];

    always #2 clk = ~clk;

    sram_bytelane_core #(.ADDR_W(AW), .LANES(LN)) u_sram_bytelane_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .be_n(be_n), .din(din), .dout(dout),
        .dout_en(dout_en), .standby(standby)
    );

    function automatic logic [DW-1:0] lane_mask(input logic [LN-1:0] b);
        return {{8{~b[1]}}, {8{~b[0]}}};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shadow_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b);
        logic [DW-1:0] m;
        m = lane_mask(b);
        shadow[a] = (shadow[a] & ~m) | (d & m);
    endtask

    // Write ended by we_n (by_ce=0) or ce_n (by_ce=1); R2, R3, R9.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b, input bit by_ce);
        addr = a; din = d; be_n = b; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        step(2);
        if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
        step(1);
        ce_n = 1'b1; we_n = 1'b1;
        step(1);
        shadow_wr(a, d, b);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [LN-1:0] b, input string req);
        logic [DW-1:0] m;
        addr = a; be_n = b; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        step(1);
        m = lane_mask(b);
        check({req, " lanes"}, {30'd0, dout_en}, {30'd0, ~b});
        check({req, " data"}, {16'd0, dout & m}, {16'd0, shadow[a] & m});
        ce_n = 1'b1; oe_n = 1'b1;
        step(1);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        check("R10 standby", {31'd0, standby}, 32'd1);
        check("R10 lanes", {30'd0, dout_en}, 32'd0);

        // R1 preload full words
        for (int a = 0; a < 64; a++) wr(AW'(a), DW'(a * 16'h0301 + 16'h1111), 2'b00, 1'b0);
        wr(AW'(100), 16'hBEEF, 2'b00, 1'b0);
        for (int a = 0; a < 64; a++) rd(AW'(a), 2'b00, "R1");

        // R3 partial writes, R9 ce-terminated on odd words
        for (int a = 0; a < 64; a++) begin
            logic [LN-1:0] b;
            b = (a % 3 == 0) ? 2'b10 : ((a % 3 == 1) ? 2'b01 : 2'b00);
            wr(AW'(a), DW'(a * 16'h1D0B ^ 16'hC3A5), b, bit'(a % 2));
        end
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 3; b++) rd(AW'(a), LN'(b), (a % 2) ? "R9" : "R3");
        end

        // R2 last-edge capture, with R8 bus off while oe_n is low
        addr = AW'(7); be_n = 2'b00; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; din = 16'h1234;
        step(1);
        check("R8 write blanks bus", {30'd0, dout_en}, 32'd0);
        din = 16'h5678;
        step(2);
        we_n = 1'b1; oe_n = 1'b1;
        step(1);
        ce_n = 1'b1;
        step(1);
        shadow_wr(AW'(7), 16'h5678, 2'b00);
        rd(AW'(7), 2'b00, "R2");

        // R6 no-lane write attempt leaves word unchanged
        addr = AW'(8); din = 16'h0F0F; be_n = 2'b11; ce_n = 1'b0; we_n = 1'b0;
        step(2);
        check("R6 standby", {31'd0, standby}, 32'd1);
        we_n = 1'b1; ce_n = 1'b1;
        step(2);
        rd(AW'(8), 2'b00, "R6");

        // Full pin sweep, i = {ce,we,oe,bhe,ble}: R4 R5 R6 R7 R8
        for (int i = 0; i < 32; i++) begin
            logic c, w, o;
            logic [LN-1:0] b;
            logic exp_sb;
            logic [LN-1:0] exp_en;
            string req;
            {c, w, o, b} = 5'(i);
            addr = AW'(100); din = DW'(16'hA5C3 ^ i);
            ce_n = c; we_n = w; oe_n = o; be_n = b;
            step(2);
            if (c) begin exp_sb = 1; exp_en = 0; req = "R5"; end
            else if (&b) begin exp_sb = 1; exp_en = 0; req = "R6"; end
            else if (!w) begin exp_sb = 0; exp_en = 0; req = "R8"; end
            else if (o) begin exp_sb = 0; exp_en = 0; req = "R7"; end
            else begin exp_sb = 0; exp_en = ~b; req = "R4"; end
            check({req, " sweep standby"}, {31'd0, standby}, {31'd0, exp_sb});
            check({req, " sweep lanes"}, {30'd0, dout_en}, {30'd0, exp_en});
            if (req == "R4")
                check("R4 sweep data", {16'd0, dout & lane_mask(b)}, {16'd0, shadow[100] & lane_mask(b)});
            ce_n = 1'b1; we_n = 1'b1;
            step(1);
            if (!c && !w && !(&b)) shadow_wr(AW'(100), DW'(16'hA5C3 ^ i), b);
        end
        rd(AW'(100), 2'b00, "R3 sweep result");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule